// File: doc/BRIEF.md
# Paged Memory Bank Decoder

This block sits beside a 6502-style CPU with a 16-bit address space. It owns an 8-bit page-select register and turns each CPU access into chip selects and upper address lines for the memories behind a 16 KB paged window at 0x8000-0xBFFF. Only one of sixteen banks is visible in that window at a time. The bank number is not a socket number. Banks are matrix-decoded onto shared devices:
- banks 0-3 go to two 32 KB cartridge ROM positions;
- banks 4-7 go to two 32 KB on-board ROM positions;
- banks 8-15 go to a single 128 KB ROM.

A static board link replaces the on-board ROM pair with four 16 KB RAM banks. A flag bit in the register overlays a 4 KB private RAM on the lowest 4 KB of the window.

Software writes the register at 0xFE30 to change banks. The new value governs every access from the next clock onward. The memories themselves, the CPU, wait states and any screen-memory switching are outside this block.

Top module: `paged_bank_decoder`

## Requirements
- R1: After reset the register holds 0x00: a read at 0xFE30 returns 0x00 on `reg_rdata`.
- R2: A valid write at exactly 0xFE30 loads bits 3:0 of the data as the bank number and bit 7 as the private-RAM flag. Bits 6:4 always read back as 0. A read at 0xFE30 returns {flag, 000, bank}, and `reg_rdata` is 0 for any other access. Writes to any other address leave the register unchanged.
- R3: No select is asserted for an address outside 0x8000-0xBFFF, including 0xFE30. `dev_ahi` is 000 whenever no select is asserted.
- R4: For banks 0-3, `sel_cart[bank[1]]` is asserted and `dev_ahi` = {00, bank[0]}.
- R5: For banks 4-7 with `ram_link` low, `sel_board[bank[1]]` is asserted and `dev_ahi` = {00, bank[0]}.
- R6: For banks 8-15, `sel_big` is asserted and `dev_ahi` = bank[2:0].
- R7: With `ram_link` high, banks 4-7 assert `sel_swram` with `dev_ahi` = {0, bank[1:0]}, and `sel_board` is never asserted. `ram_link` does not change the decode of banks 0-3 or 8-15.
- R8: With the flag set, addresses 0x8000-0x8FFF assert `sel_priv` with `dev_ahi` = 000 whatever the bank. Addresses 0x9000-0xBFFF still decode the selected bank.
- R9: A write into the window asserts its select and `ram_we` only when the target is the private RAM or the link RAM. A write aimed at any ROM asserts no select and leaves `ram_we` low. `ram_we` is never high for a read.
- R10: At most one of the selects `sel_cart[1:0]`, `sel_board[1:0]`, `sel_big`, `sel_swram`, `sel_priv` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | CPU access in progress this cycle |
| acc_rnw | input | 1 | 1 = read, 0 = write |
| acc_addr | input | 16 | CPU address |
| acc_wdata | input | 8 | CPU write data |
| ram_link | input | 1 | Static link: RAM replaces on-board ROM for banks 4-7 |
| reg_rdata | output | 8 | Register read data, valid during a read at 0xFE30 |
| sel_cart | output | 2 | Cartridge ROM position selects |
| sel_board | output | 2 | On-board ROM position selects |
| sel_big | output | 1 | 128 KB ROM select |
| sel_swram | output | 1 | Link RAM select (64 KB, four banks) |
| sel_priv | output | 1 | 4 KB private RAM select |
| dev_ahi | output | 3 | Device address bits 16:14 (low bits come straight from acc_addr) |
| ram_we | output | 1 | Write enable to the selected RAM |

## Verification
The only state in the block is the bank number and the private flag. A wrong value there shows up at once: the very first window access after the faulty write asserts the wrong select or drives the wrong `dev_ahi`, and a read of 0xFE30 exposes it directly. A decode fault is visible in the same cycle as the access, because the selects are purely combinational from the address and the register. The bench therefore pairs every register write with an immediate window access, and it probes the 4 KB boundary, the window edges and the register address itself.

// File: rtl/paged_pkg.sv
package paged_pkg;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_CART,
        TGT_BOARD,
        TGT_BIG,
        TGT_SWRAM,
        TGT_PRIV
    } tgt_e;

    typedef struct packed {
        tgt_e       kind;
        logic       pos;
        logic [2:0] ahi;
    } route_t;

endpackage

// File: rtl/pr_reg.sv
module pr_reg #(
    parameter int BANK_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [BANK_W-1:0] bank_q,
    output logic              priv_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
            priv_q <= 1'b0;
        end else if (wr_en) begin
            bank_q <= wdata[BANK_W-1:0];
            priv_q <= wdata[DATA_W-1];
        end
    end
endmodule

// File: rtl/pr_target_sel.sv
module pr_target_sel
    import paged_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BANK_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BANK_W-1:0] bank,
    input  logic              priv,
    input  logic              link,
    output route_t            route
);
    localparam int TOP = ADDR_W - 1;

    logic in_win;
    logic in_priv;

    assign in_win  = (addr[TOP:TOP-1] == 2'b10);
    assign in_priv = (addr[TOP-2:TOP-3] == 2'b00);

    always_comb begin
        route = '{kind: TGT_NONE, pos: 1'b0, ahi: 3'b000};
        if (in_win) begin
            if (priv && in_priv) begin
                route.kind = TGT_PRIV;
            end else if (bank[3]) begin
                route.kind = TGT_BIG;
                route.ahi  = bank[2:0];
            end else if (bank[2] && link) begin
                route.kind = TGT_SWRAM;
                route.ahi  = {1'b0, bank[1:0]};
            end else begin
                route.kind = bank[2] ? TGT_BOARD : TGT_CART;
                route.pos  = bank[1];
                route.ahi  = {2'b00, bank[0]};
            end
        end
    end
endmodule

// File: rtl/pr_cs_drive.sv
module pr_cs_drive
    import paged_pkg::*;
#(
    parameter int NPOS = 2
) (
    input  logic            valid,
    input  logic            rnw,
    input  route_t          route,
    output logic [NPOS-1:0] sel_cart,
    output logic [NPOS-1:0] sel_board,
    output logic            sel_big,
    output logic            sel_swram,
    output logic            sel_priv,
    output logic [2:0]      dev_ahi,
    output logic            ram_we
);
    logic is_ram;
    logic go;

    assign is_ram = (route.kind == TGT_SWRAM) || (route.kind == TGT_PRIV);
    assign go     = valid && (rnw || is_ram);
    assign ram_we = valid && !rnw && is_ram;

    generate
        for (genvar p = 0; p < NPOS; p++) begin : g_pos
            assign sel_cart[p]  = go && (route.kind == TGT_CART)
                                     && (route.pos == p[0]);
            assign sel_board[p] = go && (route.kind == TGT_BOARD)
                                     && (route.pos == p[0]);
        end
    endgenerate

    assign sel_big   = go && (route.kind == TGT_BIG);
    assign sel_swram = go && (route.kind == TGT_SWRAM);
    assign sel_priv  = go && (route.kind == TGT_PRIV);

    always_comb begin
        dev_ahi = 3'b000;
        if (go && route.kind != TGT_NONE) begin
            dev_ahi = route.ahi;
        end
    end
endmodule

// File: rtl/paged_bank_decoder.sv
module paged_bank_decoder
    import paged_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter int          DATA_W   = 8,
    parameter int          BANK_W   = 4,
    parameter logic [15:0] REG_ADDR = 16'hFE30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_rnw,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic              ram_link,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [1:0]        sel_cart,
    output logic [1:0]        sel_board,
    output logic              sel_big,
    output logic              sel_swram,
    output logic              sel_priv,
    output logic [2:0]        dev_ahi,
    output logic              ram_we
);
    localparam int RSV_W = DATA_W - 1 - BANK_W;

    logic              reg_hit;
    logic [BANK_W-1:0] bank_q;
    logic              priv_q;
    route_t            route;

    assign reg_hit = acc_valid && (acc_addr == REG_ADDR[ADDR_W-1:0]);

    pr_reg #(.BANK_W(BANK_W), .DATA_W(DATA_W)) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_hit && !acc_rnw),
        .wdata  (acc_wdata),
        .bank_q (bank_q),
        .priv_q (priv_q)
    );

    assign reg_rdata = (reg_hit && acc_rnw)
                       ? {priv_q, {RSV_W{1'b0}}, bank_q} : '0;

    pr_target_sel #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_tsel (
        .addr  (acc_addr),
        .bank  (bank_q),
        .priv  (priv_q),
        .link  (ram_link),
        .route (route)
    );

    pr_cs_drive #(.NPOS(2)) u_drv (
        .valid     (acc_valid),
        .rnw       (acc_rnw),
        .route     (route),
        .sel_cart  (sel_cart),
        .sel_board (sel_board),
        .sel_big   (sel_big),
        .sel_swram (sel_swram),
        .sel_priv  (sel_priv),
        .dev_ahi   (dev_ahi),
        .ram_we    (ram_we)
    );
endmodule

// File: rtl/pr_checker.sv
module pr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic        acc_rnw,
    input logic [15:0] acc_addr,
    input logic [7:0]  acc_wdata,
    input logic        ram_link,
    input logic [7:0]  reg_rdata,
    input logic [1:0]  sel_cart,
    input logic [1:0]  sel_board,
    input logic        sel_big,
    input logic        sel_swram,
    input logic        sel_priv,
    input logic [2:0]  dev_ahi,
    input logic        ram_we,
    input logic [3:0]  bank_q,
    input logic        priv_q
);
    logic [6:0] sels;
    assign sels = {sel_priv, sel_swram, sel_big, sel_board, sel_cart};

    a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sels));

    a_r3_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_addr[15:14] != 2'b10) |-> (sels == 7'd0 && dev_ahi == 3'd0));

    a_r9_rom_write: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_rnw) |-> (sel_cart == 2'd0 && sel_board == 2'd0 && !sel_big));

    a_r9_no_we_read: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rnw |-> !ram_we);

    a_r2_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[6:4] == 3'b000);

    a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_rnw && acc_addr == 16'hFE30)
        |=> (bank_q == $past(acc_wdata[3:0]) && priv_q == $past(acc_wdata[7])));

    a_r7_link_board: assert property (@(posedge clk) disable iff (!rst_n)
        ram_link |-> (sel_board == 2'd0));

    a_r8_priv: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_priv) |-> (priv_q && acc_addr[15:12] == 4'h8 && dev_ahi == 3'd0));
endmodule

bind paged_bank_decoder pr_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_rnw   (acc_rnw),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .ram_link  (ram_link),
    .reg_rdata (reg_rdata),
    .sel_cart  (sel_cart),
    .sel_board (sel_board),
    .sel_big   (sel_big),
    .sel_swram (sel_swram),
    .sel_priv  (sel_priv),
    .dev_ahi   (dev_ahi),
    .ram_we    (ram_we),
    .bank_q    (bank_q),
    .priv_q    (priv_q)
);

// File: tb/paged_bank_decoder_test.sv
`timescale 1ns/1ps
module paged_bank_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_rnw = 1'b1;
    logic [15:0] acc_addr = 16'h0000;
    logic [7:0]  acc_wdata = 8'h00;
    logic        ram_link = 1'b0;
    logic [7:0]  reg_rdata;
    logic [1:0]  sel_cart, sel_board;
    logic        sel_big, sel_swram, sel_priv, ram_we;
    logic [2:0]  dev_ahi;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    paged_bank_decoder uut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_rnw(acc_rnw),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .ram_link(ram_link),
        .reg_rdata(reg_rdata), .sel_cart(sel_cart), .sel_board(sel_board),
        .sel_big(sel_big), .sel_swram(sel_swram), .sel_priv(sel_priv),
        .dev_ahi(dev_ahi), .ram_we(ram_we)
    );

    // Vector: reg(8) link(1) addr(16) rnw(1) sels{priv,swram,big,board1,board0,cart1,cart0}(7) ahi(3) we(1)
    localparam int NV = 23;
    localparam logic [36:0] VEC [NV] = '{
        {8'h00, 1'b0, 16'h8000, 1'b1, 7'b0000001, 3'd0, 1'b0}, // R4
        {8'h01, 1'b0, 16'hA123, 1'b1, 7'b0000001, 3'd1, 1'b0}, // R4
        {8'h03, 1'b0, 16'hBFFF, 1'b1, 7'b0000010, 3'd1, 1'b0}, // R4
        {8'h02, 1'b0, 16'h8000, 1'b1, 7'b0000010, 3'd0, 1'b0}, // R4
        {8'h04, 1'b0, 16'h9000, 1'b1, 7'b0000100, 3'd0, 1'b0}, // R5
        {8'h07, 1'b0, 16'h8000, 1'b1, 7'b0001000, 3'd1, 1'b0}, // R5
        {8'h08, 1'b0, 16'h8000, 1'b1, 7'b0010000, 3'd0, 1'b0}, // R6
        {8'h0D, 1'b0, 16'hB000, 1'b1, 7'b0010000, 3'd5, 1'b0}, // R6
        {8'h0F, 1'b1, 16'h8000, 1'b1, 7'b0010000, 3'd7, 1'b0}, // R6, R7
        {8'h05, 1'b1, 16'h8000, 1'b1, 7'b0100000, 3'd1, 1'b0}, // R7
        {8'h06, 1'b1, 16'h8000, 1'b0, 7'b0100000, 3'd2, 1'b1}, // R7, R9
        {8'h07, 1'b1, 16'hBFFF, 1'b1, 7'b0100000, 3'd3, 1'b0}, // R7
        {8'h01, 1'b1, 16'h8000, 1'b1, 7'b0000001, 3'd1, 1'b0}, // R7
        {8'h84, 1'b0, 16'h8FFF, 1'b1, 7'b1000000, 3'd0, 1'b0}, // R8
        {8'h84, 1'b0, 16'h9000, 1'b1, 7'b0000100, 3'd0, 1'b0}, // R8
        {8'h8B, 1'b0, 16'h8000, 1'b0, 7'b1000000, 3'd0, 1'b1}, // R8, R9
        {8'h8B, 1'b0, 16'hA000, 1'b0, 7'b0000000, 3'd0, 1'b0}, // R9
        {8'h03, 1'b0, 16'h7FFF, 1'b1, 7'b0000000, 3'd0, 1'b0}, // R3
        {8'h03, 1'b0, 16'hC000, 1'b1, 7'b0000000, 3'd0, 1'b0}, // R3
        {8'h03, 1'b0, 16'hFE30, 1'b1, 7'b0000000, 3'd0, 1'b0}, // R3
        {8'h0C, 1'b0, 16'hA000, 1'b0, 7'b0000000, 3'd0, 1'b0}, // R9
        {8'h00, 1'b0, 16'h8000, 1'b0, 7'b0000000, 3'd0, 1'b0}, // R9
        {8'h84, 1'b1, 16'h8000, 1'b1, 7'b1000000, 3'd0, 1'b0}  // R8
    };
    localparam int VREQ [NV] = '{4,4,4,4,5,5,6,6,6,7,7,7,7,8,8,8,9,3,3,3,9,9,8};

    task automatic wr_reg(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_rnw = 1'b0; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0; acc_rnw = 1'b1;
    endtask

    task automatic access(input logic [15:0] a, input logic rnw);
        @(negedge clk);
        acc_valid = 1'b1; acc_rnw = rnw; acc_addr = a;
        #2;
    endtask

    task automatic check_rd(input string tag, input logic [7:0] exp);
        access(16'hFE30, 1'b1);
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s reg_rdata=%h expected=%h", tag, reg_rdata, exp);
        end
        acc_valid = 1'b0;
    endtask

    task automatic check_dec(input string tag, input logic [6:0] es,
                             input logic [2:0] ea, input logic ew);
        logic [6:0] s;
        s = {sel_priv, sel_swram, sel_big, sel_board, sel_cart};
        checks++;
        if (s !== es || dev_ahi !== ea || ram_we !== ew) begin
            errors++;
            $display("FAIL %s sels=%b ahi=%0d we=%b expected sels=%b ahi=%0d we=%b",
                     tag, s, dev_ahi, ram_we, es, ea, ew);
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #23 rst_n = 1'b1;

        // R1 reset state
        check_rd("R1 reset value", 8'h00);
        access(16'h8000, 1'b1);
        check_dec("R1 reset decodes bank 0", 7'b0000001, 3'd0, 1'b0);
        acc_valid = 1'b0;

        // table walk
        for (int i = 0; i < NV; i++) begin
            logic [36:0] v;
            v = VEC[i];
            ram_link = v[28];
            wr_reg(16'hFE30, v[36:29]);
            access(v[27:12], v[11]);
            check_dec($sformatf("R%0d vector %0d", VREQ[i], i), v[10:4], v[3:1], v[0]);
            acc_valid = 1'b0;
        end
        ram_link = 1'b0;

        // R2 reserved bits read as zero, flag and bank kept
        wr_reg(16'hFE30, 8'hF5);
        check_rd("R2 reserved bits", 8'h85);
        access(16'hA000, 1'b1);
        check_dec("R2 bank after F5", 7'b0000100, 3'd1, 1'b0);
        access(16'h8000, 1'b1);
        check_dec("R2 flag after F5", 7'b1000000, 3'd0, 1'b0);
        acc_valid = 1'b0;

        // R2 write to neighbour address leaves register
        wr_reg(16'hFE31, 8'h0A);
        check_rd("R2 neighbour write ignored", 8'h85);
        wr_reg(16'hFE30, 8'h8F);
        check_rd("R2 write 8F", 8'h8F);

        // R2 rdata zero for other address read
        access(16'h8000, 1'b1);
        checks++;
        if (reg_rdata !== 8'h00) begin
            errors++;
            $display("FAIL R2 rdata off-register=%h expected=00", reg_rdata);
        end
        acc_valid = 1'b0;

        // R9 window write to ROM leaves no select, RAM write in private region ok
        wr_reg(16'hFE30, 8'h09);
        access(16'h8000, 1'b0);
        check_dec("R9 write to big ROM ignored", 7'b0000000, 3'd0, 1'b0);
        acc_valid = 1'b0;
        check_rd("R9 register unchanged by window write", 8'h09);

        // R10 idle: no valid access, no select
        @(negedge clk);
        acc_addr = 16'h8000; acc_valid = 1'b0; #2;
        check_dec("R10 idle no select", 7'b0000000, 3'd0, 1'b0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule